// File: doc/BRIEF.md
# Pixel Histogram Accumulator for Pipelined Synchronous SRAM

This block builds per-pixel calibration histograms in an external synchronous SRAM of 36-bit words. Each incoming hit carries a pixel address and a 4-bit time-over-threshold (ToT) value. For every hit, the word that belongs to the pixel is read, three packed accumulators are updated, and the word is written back. The accumulators are the hit count, the sum of ToT and the sum of ToT squared. Each accumulator saturates at its full-scale value and does not wrap.

Hits first enter a small queue. A scheduler then takes up to eight hits into a burst. Hits in one burst that target the same pixel are merged into one pending increment, so that pixel gets only one read and one write. The scheduler issues all reads of the burst back to back and waits for the data to come back from the pipelined SRAM. After one idle cycle for bus turnaround, it issues all writes back to back. Grouping the reads and the writes this way keeps the shared data bus from reversing direction on every access.

When acquisition has ended, a readout request gives a start pixel and a length. The block then streams the stored words out in ascending pixel order, one word per cycle.

Top module: `hist_sram_ctrl`

## Requirements
- R1: Each pixel has one word at SRAM address equal to the pixel number. Bits [7:0] hold the hit count, bits [19:8] hold the ToT sum and bits [35:20] hold the ToT-squared sum. Every accepted hit adds 1, tot and tot*tot to these fields.
- R2: Each field saturates independently at its all-ones value (255, 4095 and 65535) and never wraps.
- R3: Several hits to one pixel inside one burst give the same stored result as applying those hits one after another.
- R4: The block never asserts `sram_rd` and `sram_we` in the same cycle. A burst is a run of at most 8 consecutive read cycles followed by a run of at most 8 consecutive write cycles.
- R5: Read data is valid on `sram_rdata` two cycles after the cycle in which the read address is presented. The first write of a burst is presented exactly four cycles after the last read of that burst, which leaves one idle cycle after the data returns.
- R6: After the last write cycle of a burst, the cycle that follows has no read.
- R7: A hit is accepted on a cycle in which `hit_valid` and `hit_ready` are both high. `hit_ready` goes low only while the 16-entry queue is full, and no accepted hit is lost.
- R8: A readout request with length N reads N consecutive pixels starting at `ro_base`. It returns them on `ro_valid`, `ro_pix` and `ro_data` in ascending order, while `ro_busy` is high.
- R9: A readout request is dropped unless the block is idle with an empty hit queue in the cycle of the request. A dropped request produces no `ro_valid` and no `ro_busy`.
- R10: After reset, `hit_ready` is 1 and `sram_rd`, `sram_we`, `ro_busy` and `ro_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Queue can take a hit |
| hit_pix | input | 20 | Pixel address of the hit |
| hit_tot | input | 4 | ToT value of the hit |
| sram_addr | output | 20 | SRAM word address |
| sram_rd | output | 1 | Read strobe |
| sram_we | output | 1 | Write strobe; the controller drives the data bus |
| sram_wdata | output | 36 | Write data |
| sram_rdata | input | 36 | Read data, valid two cycles after the read |
| ro_start | input | 1 | Readout request pulse |
| ro_base | input | 20 | First pixel to read out |
| ro_len | input | 21 | Number of pixels to read out; 0 does nothing |
| ro_busy | output | 1 | Readout in progress |
| ro_valid | output | 1 | Readout word valid |
| ro_pix | output | 20 | Pixel of the readout word |
| ro_data | output | 36 | Stored histogram word |

## Verification
Assertions check the bus discipline on every cycle. These checks cover read/write exclusivity, the maximum burst run lengths, the exact four-cycle gap between the last read and the first write, the idle cycle after the writes, the ascending order of readout pixels, and the gating of readout on an idle, empty queue. The arithmetic can only be shown by the bench scenarios, which compare read-back words against a sequential reference model. These scenarios cover the packing of the three fields, saturation of each field, and merging of repeated pixels inside a burst. The same applies to the rule that a readout request made while hits are still in flight has no effect.

// File: rtl/hist_sram_ctrl.sv
module hist_sram_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int TOT_W      = 4,
  parameter int CNT_W      = 8,
  parameter int SUM_W      = 12,
  parameter int SQ_W       = 16,
  parameter int BURST      = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hit_valid,
  output logic                              hit_ready,
  input  logic [ADDR_W-1:0]                 hit_pix,
  input  logic [TOT_W-1:0]                  hit_tot,
  output logic [ADDR_W-1:0]                 sram_addr,
  output logic                              sram_rd,
  output logic                              sram_we,
  output logic [CNT_W+SUM_W+SQ_W-1:0]       sram_wdata,
  input  logic [CNT_W+SUM_W+SQ_W-1:0]       sram_rdata,
  input  logic                              ro_start,
  input  logic [ADDR_W-1:0]                 ro_base,
  input  logic [ADDR_W:0]                   ro_len,
  output logic                              ro_busy,
  output logic                              ro_valid,
  output logic [ADDR_W-1:0]                 ro_pix,
  output logic [CNT_W+SUM_W+SQ_W-1:0]       ro_data
);
  localparam int DATA_W = CNT_W + SUM_W + SQ_W;
  localparam int SLOT_W = (BURST > 1) ? $clog2(BURST) : 1;
  localparam int HC_W   = $clog2(BURST + 1);
  localparam int IS_W   = TOT_W + HC_W;
  localparam int IQ_W   = 2 * TOT_W + HC_W;
  localparam int FP_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int RUN_W  = HC_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_GATHER, S_READ, S_DRAIN, S_TURN, S_WRITE, S_RO, S_RODRAIN
  } st_t;

  st_t state;

  logic [ADDR_W-1:0] q_pix [FIFO_DEPTH];
  logic [TOT_W-1:0]  q_tot [FIFO_DEPTH];
  logic [FP_W-1:0]   q_wp, q_rp;
  logic [FP_W:0]     q_cnt;
  logic              q_push, q_pop, q_empty;

  assign hit_ready = q_cnt != (FP_W+1)'(FIFO_DEPTH);
  assign q_empty   = q_cnt == '0;
  assign q_push    = hit_valid && hit_ready;

  logic [ADDR_W-1:0] slot_pix [BURST];
  logic [HC_W-1:0]   inc_c    [BURST];
  logic [IS_W-1:0]   inc_s    [BURST];
  logic [IQ_W-1:0]   inc_q    [BURST];
  logic [DATA_W-1:0] old_w    [BURST];
  logic [HC_W-1:0]   n_slots, n_hits, idx;

  logic [ADDR_W-1:0] h_pix;
  logic [TOT_W-1:0]  h_tot;
  logic [2*TOT_W-1:0] h_sq;
  assign h_pix = q_pix[q_rp];
  assign h_tot = q_tot[q_rp];
  assign h_sq  = (2*TOT_W)'(h_tot) * (2*TOT_W)'(h_tot);
  assign q_pop = (state == S_GATHER) && !q_empty && (n_hits != HC_W'(BURST));

  logic              m_hit;
  logic [SLOT_W-1:0] m_idx;
  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int i = 0; i < BURST; i++) begin
      if (!m_hit && (HC_W'(i) < n_slots) && (slot_pix[i] == h_pix)) begin
        m_hit = 1'b1;
        m_idx = SLOT_W'(i);
      end
    end
  end

  logic [SLOT_W-1:0] a_idx, wsel;
  assign a_idx = n_slots[SLOT_W-1:0];
  assign wsel  = idx[SLOT_W-1:0];

  logic [DATA_W-1:0] wold, wval;
  logic [CNT_W:0]    sum_c;
  logic [SUM_W:0]    sum_s;
  logic [SQ_W:0]     sum_q;
  assign wold  = old_w[wsel];
  assign sum_c = {1'b0, wold[CNT_W-1:0]} + (CNT_W+1)'(inc_c[wsel]);
  assign sum_s = {1'b0, wold[CNT_W +: SUM_W]} + (SUM_W+1)'(inc_s[wsel]);
  assign sum_q = {1'b0, wold[CNT_W+SUM_W +: SQ_W]} + (SQ_W+1)'(inc_q[wsel]);
  assign wval  = {sum_q[SQ_W]  ? {SQ_W{1'b1}}  : sum_q[SQ_W-1:0],
                  sum_s[SUM_W] ? {SUM_W{1'b1}} : sum_s[SUM_W-1:0],
                  sum_c[CNT_W] ? {CNT_W{1'b1}} : sum_c[CNT_W-1:0]};

  logic [SLOT_W-1:0] sram_slot;
  logic              p1_v, p2_v;
  logic [ADDR_W-1:0] p1_addr, p2_addr;
  logic [SLOT_W-1:0] p1_slot, p2_slot;
  logic              ro_mode;
  logic [ADDR_W-1:0] ro_next;
  logic [ADDR_W:0]   ro_left;

  assign ro_busy = ro_mode;

  always_ff @(posedge clk) begin
    if (q_push) begin
      q_pix[q_wp] <= hit_pix;
      q_tot[q_wp] <= hit_tot;
    end
    if (q_pop) begin
      if (m_hit) begin
        inc_c[m_idx] <= inc_c[m_idx] + HC_W'(1);
        inc_s[m_idx] <= inc_s[m_idx] + IS_W'(h_tot);
        inc_q[m_idx] <= inc_q[m_idx] + IQ_W'(h_sq);
      end else begin
        slot_pix[a_idx] <= h_pix;
        inc_c[a_idx]    <= HC_W'(1);
        inc_s[a_idx]    <= IS_W'(h_tot);
        inc_q[a_idx]    <= IQ_W'(h_sq);
      end
    end
    if (p2_v && !ro_mode) old_w[p2_slot] <= sram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      q_wp       <= '0;
      q_rp       <= '0;
      q_cnt      <= '0;
      n_slots    <= '0;
      n_hits     <= '0;
      idx        <= '0;
      sram_addr  <= '0;
      sram_rd    <= 1'b0;
      sram_we    <= 1'b0;
      sram_wdata <= '0;
      sram_slot  <= '0;
      p1_v       <= 1'b0;
      p2_v       <= 1'b0;
      p1_addr    <= '0;
      p2_addr    <= '0;
      p1_slot    <= '0;
      p2_slot    <= '0;
      ro_mode    <= 1'b0;
      ro_next    <= '0;
      ro_left    <= '0;
      ro_valid   <= 1'b0;
      ro_pix     <= '0;
      ro_data    <= '0;
    end else begin
      if (q_push) q_wp <= q_wp + FP_W'(1);
      if (q_pop)  q_rp <= q_rp + FP_W'(1);
      case ({q_push, q_pop})
        2'b10:   q_cnt <= q_cnt + (FP_W+1)'(1);
        2'b01:   q_cnt <= q_cnt - (FP_W+1)'(1);
        default: q_cnt <= q_cnt;
      endcase

      p1_v    <= sram_rd;
      p1_addr <= sram_addr;
      p1_slot <= sram_slot;
      p2_v    <= p1_v;
      p2_addr <= p1_addr;
      p2_slot <= p1_slot;

      ro_valid <= 1'b0;
      if (p2_v && ro_mode) begin
        ro_valid <= 1'b1;
        ro_pix   <= p2_addr;
        ro_data  <= sram_rdata;
      end

      case (state)
        S_IDLE: begin
          sram_rd <= 1'b0;
          sram_we <= 1'b0;
          if (!q_empty) begin
            n_slots <= '0;
            n_hits  <= '0;
            state   <= S_GATHER;
          end else if (ro_start && ro_len != '0) begin
            ro_mode   <= 1'b1;
            sram_rd   <= 1'b1;
            sram_addr <= ro_base;
            ro_next   <= ro_base + ADDR_W'(1);
            ro_left   <= ro_len - (ADDR_W+1)'(1);
            state     <= S_RO;
          end
        end
        S_GATHER: begin
          if (q_pop) begin
            n_hits <= n_hits + HC_W'(1);
            if (!m_hit) n_slots <= n_slots + HC_W'(1);
          end else begin
            idx   <= '0;
            state <= S_READ;
          end
        end
        S_READ: begin
          sram_rd   <= 1'b1;
          sram_addr <= slot_pix[wsel];
          sram_slot <= wsel;
          idx       <= idx + HC_W'(1);
          if (idx == n_slots - HC_W'(1)) state <= S_DRAIN;
        end
        S_DRAIN: begin
          sram_rd <= 1'b0;
          if (!sram_rd && !p1_v && p2_v) begin
            idx   <= '0;
            state <= S_TURN;
          end
        end
        S_TURN, S_WRITE: begin
          if (idx != n_slots) begin
            sram_we    <= 1'b1;
            sram_addr  <= slot_pix[wsel];
            sram_wdata <= wval;
            idx        <= idx + HC_W'(1);
            state      <= S_WRITE;
          end else begin
            sram_we <= 1'b0;
            state   <= S_IDLE;
          end
        end
        S_RO: begin
          if (ro_left != '0) begin
            sram_addr <= ro_next;
            ro_next   <= ro_next + ADDR_W'(1);
            ro_left   <= ro_left - (ADDR_W+1)'(1);
          end else begin
            sram_rd <= 1'b0;
            state   <= S_RODRAIN;
          end
        end
        default: begin
          sram_rd <= 1'b0;
          if (!sram_rd && !p1_v && !p2_v) begin
            ro_mode <= 1'b0;
            state   <= S_IDLE;
          end
        end
      endcase
    end
  end

  logic [RUN_W-1:0] rd_run, wr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= !sram_rd ? '0 : (rd_run == '1 ? rd_run : rd_run + RUN_W'(1));
      wr_run <= !sram_we ? '0 : (wr_run == '1 ? wr_run : wr_run + RUN_W'(1));
    end
  end

  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd && sram_we));
  assert_wr_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> wr_run < RUN_W'(BURST));
  assert_rd_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_rd && !ro_mode) |-> rd_run < RUN_W'(BURST));
  assert_turn_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we) |-> (!$past(sram_rd, 1) && !$past(sram_rd, 2) &&
                        !$past(sram_rd, 3) && $past(sram_rd, 4)));
  assert_turn_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we) |-> !sram_rd);
  assert_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> !q_empty || $past(q_pop));
  assert_ro_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_valid && $past(ro_valid)) |-> ro_pix == ADDR_W'($past(ro_pix) + ADDR_W'(1)));
  assert_ro_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ro_valid |-> ro_busy);
  assert_ro_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ro_busy) |-> $past(state == S_IDLE && q_empty && ro_start));
endmodule

// File: tb/tb_hist_sram_ctrl.sv
module tb_hist_sram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_valid = 1'b0;
  logic        hit_ready;
  logic [19:0] hit_pix = '0;
  logic [3:0]  hit_tot = '0;
  logic [19:0] sram_addr;
  logic        sram_rd, sram_we;
  logic [35:0] sram_wdata;
  logic [35:0] sram_rdata = '0;
  logic        ro_start = 1'b0;
  logic [19:0] ro_base = '0;
  logic [20:0] ro_len = '0;
  logic        ro_busy, ro_valid;
  logic [19:0] ro_pix;
  logic [35:0] ro_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [35:0] mem [64];
  logic [35:0] exp_w [64];
  logic [35:0] rpipe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_sram_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_pix(hit_pix), .hit_tot(hit_tot),
    .sram_addr(sram_addr), .sram_rd(sram_rd), .sram_we(sram_we),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .ro_start(ro_start), .ro_base(ro_base), .ro_len(ro_len),
    .ro_busy(ro_busy), .ro_valid(ro_valid), .ro_pix(ro_pix), .ro_data(ro_data));

  always @(posedge clk) begin
    if (sram_we) mem[sram_addr[5:0]] <= sram_wdata;
    rpipe      <= sram_rd ? mem[sram_addr[5:0]] : '0;
    sram_rdata <= rpipe;
  end

  function automatic logic [35:0] acc(input logic [35:0] w, input int t);
    int c, s, q;
    c = int'(w[7:0]) + 1;
    s = int'(w[19:8]) + t;
    q = int'(w[35:20]) + t * t;
    if (c > 255)   c = 255;
    if (s > 4095)  s = 4095;
    if (q > 65535) q = 65535;
    return {q[15:0], s[11:0], c[7:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  int cyc = 0;
  int last_rd = 0;
  int rd_run = 0;
  int wr_run = 0;
  bit prev_we = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sram_rd && sram_we) chk("R4 rd/we overlap", 1, 0);
      rd_run = sram_rd ? rd_run + 1 : 0;
      wr_run = sram_we ? wr_run + 1 : 0;
      if (!ro_busy && rd_run > 8) chk("R4 read run", rd_run, 8);
      if (wr_run > 8) chk("R4 write run", wr_run, 8);
      if (sram_we && !prev_we) chk("R5 read-to-write gap", cyc - last_rd, 4);
      if (!sram_we && prev_we) chk("R6 read after write", sram_rd, 0);
      if (sram_rd) last_rd = cyc;
      prev_we = sram_we;
    end
  end

  task automatic send_hit(input int pix, input int tot);
    hit_valid = 1'b1;
    hit_pix   = 20'(pix);
    hit_tot   = 4'(tot);
    while (!hit_ready) @(negedge clk);
    @(negedge clk);
    hit_valid = 1'b0;
    exp_w[pix] = acc(exp_w[pix], tot);
  endtask

  task automatic do_ro(input int base, input int len, input string req);
    int got;
    int nxt;
    got = 0;
    nxt = base;
    ro_start = 1'b1;
    ro_base  = 20'(base);
    ro_len   = 21'(len);
    @(negedge clk);
    ro_start = 1'b0;
    for (int k = 0; k < len + 12; k++) begin
      if (ro_valid) begin
        chk({req, " R8 pixel order"}, ro_pix, nxt);
        chk({req, " word"}, ro_data, exp_w[nxt[5:0]]);
        nxt++;
        got++;
      end
      @(negedge clk);
    end
    chk({req, " R8 word count"}, got, len);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd1789));
    for (int i = 0; i < 64; i++) begin
      mem[i]   = '0;
      exp_w[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 hit_ready", hit_ready, 1);
    chk("R10 sram_rd", sram_rd, 0);
    chk("R10 sram_we", sram_we, 0);
    chk("R10 ro_busy", ro_busy, 0);
    chk("R10 ro_valid", ro_valid, 0);

    send_hit(5, 3);
    repeat (40) @(negedge clk);
    chk("R1 packed fields", exp_w[5], {16'd9, 12'd3, 8'd1});
    do_ro(5, 1, "R1 single hit");

    for (int i = 0; i < 8; i++) send_hit((i % 2) ? 8 : 7, i + 1);
    send_hit(7, 15);
    send_hit(7, 15);
    repeat (80) @(negedge clk);
    do_ro(6, 4, "R3 repeated pixels");

    for (int i = 0; i < 400; i++) begin
      send_hit($urandom_range(0, 15), $urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    repeat (150) @(negedge clk);
    do_ro(0, 16, "R7 random stream");

    for (int i = 0; i < 300; i++) send_hit(40, 15);
    for (int i = 0; i < 260; i++) send_hit(41, 0);
    repeat (150) @(negedge clk);
    chk("R2 expected saturation", exp_w[40], {16'hFFFF, 12'hFFF, 8'hFF});
    chk("R2 count-only saturation", exp_w[41], {16'd0, 12'd0, 8'hFF});
    do_ro(40, 2, "R2 saturation");

    for (int i = 0; i < 4; i++) send_hit(30, 2);
    ro_start = 1'b1;
    ro_base  = 20'd30;
    ro_len   = 21'd1;
    @(negedge clk);
    ro_start = 1'b0;
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      if (ro_valid || ro_busy) seen++;
      @(negedge clk);
    end
    chk("R9 dropped request activity", seen, 0);
    do_ro(30, 1, "R9 later readout");

    do_ro(50, 3, "R8 untouched pixels");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule